// File: doc/BRIEF.md
# Register Rename Status Table

This block is the floating-point register file of a tag-renamed out-of-order core, with a producer-status field beside each register. When an instruction issues, the block looks up two source registers. For each one it returns either the stored value or the tag of the station that will produce it. In the same cycle it records the issuing station's tag as the pending producer of the destination register.

A shared result bus carries a source tag and a data word. The block watches this bus and writes a register only while the broadcast tag equals the producer that register still expects. If a later issue has already claimed the register, an older overlapping result is dropped silently. As a result, the last writer in program order always decides the final value.

Tags run from 1 to 15, and the status value 0 means that no write is pending. The source lookups are combinational. Issue and broadcast updates take effect at the next rising clock edge.

Top module: `rename_regfile`

## Requirements
- R1: A synchronous reset, active high, sets every register value to zero and every status field to 0 (blank). After reset, every source lookup returns value 0 with tag 0.
- R2: When no broadcast hits the register, each source port returns the stored value and the current status field of the addressed register. A returned tag of 0 means the value is ready.
- R3: When `iss_valid` is high, the destination register's status becomes `iss_tag` from the next cycle on. Source lookups in the issuing cycle see the status from before that issue, even when a source equals the destination.
- R4: A later issue to a register that already has a pending producer replaces the recorded tag with the new one.
- R5: A broadcast whose tag equals a register's nonzero status writes `bc_data` into that register and returns its status to 0 at the next edge.
- R6: A broadcast whose tag differs from a register's status leaves that register's value and status unchanged. This is how an older overlapping write is dropped.
- R7: When a broadcast hits a register that is being read in the same cycle, the lookup returns `bc_data` with tag 0.
- R8: When a broadcast hits the register that is also the new issue destination in the same cycle, the value is written and the status takes the new `iss_tag`.
- R9: A broadcast is ignored, with no register value or status changed, when `bc_valid` is low or `bc_tag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_src_a | input | 4 | First source register index |
| iss_src_b | input | 4 | Second source register index |
| iss_dst | input | 4 | Destination register index |
| iss_tag | input | 4 | Tag of the issuing station (1 to 15) |
| bc_valid | input | 1 | Result bus carries a result |
| bc_tag | input | 4 | Tag of the station producing the result |
| bc_data | input | 64 | Result value |
| rd_a_val | output | 64 | Value for the first source |
| rd_a_tag | output | 4 | Producer tag for the first source, 0 if ready |
| rd_b_val | output | 64 | Value for the second source |
| rd_b_tag | output | 4 | Producer tag for the second source, 0 if ready |

## Verification
The assertions check the following on every cycle:
- the cleared state after reset;
- the destination status that follows each issue;
- the same-cycle forwarding on the first read port;
- that a mismatching or invalid broadcast leaves the values untouched.

The bench scenarios show the behaviour that needs ordered histories:
- a write-after-write pair, where the stale result arrives after the newer issue and is dropped;
- a broadcast that collides with a new issue to the same register;
- a reset in the middle of a run with traffic pending.

// File: rtl/rename_regfile.sv
module rename_regfile #(
  parameter int NREG = 16,
  parameter int DW   = 64,
  parameter int TW   = 4,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          iss_valid,
  input  logic [AW-1:0] iss_src_a,
  input  logic [AW-1:0] iss_src_b,
  input  logic [AW-1:0] iss_dst,
  input  logic [TW-1:0] iss_tag,
  input  logic          bc_valid,
  input  logic [TW-1:0] bc_tag,
  input  logic [DW-1:0] bc_data,
  output logic [DW-1:0] rd_a_val,
  output logic [TW-1:0] rd_a_tag,
  output logic [DW-1:0] rd_b_val,
  output logic [TW-1:0] rd_b_tag
);

  logic [NREG-1:0][DW-1:0] vals;
  logic [NREG-1:0][TW-1:0] stat;

  wire bc_live = bc_valid && (bc_tag != '0);
  wire hit_a   = bc_live && (stat[iss_src_a] == bc_tag);
  wire hit_b   = bc_live && (stat[iss_src_b] == bc_tag);

  assign rd_a_val = hit_a ? bc_data : vals[iss_src_a];
  assign rd_a_tag = hit_a ? '0      : stat[iss_src_a];
  assign rd_b_val = hit_b ? bc_data : vals[iss_src_b];
  assign rd_b_tag = hit_b ? '0      : stat[iss_src_b];

  always_ff @(posedge clk) begin
    if (rst) begin
      vals <= '0;
      stat <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (bc_live && stat[i] == bc_tag) begin
          vals[i] <= bc_data;
          stat[i] <= '0;
        end
        if (iss_valid && iss_dst == AW'(i))
          stat[i] <= iss_tag;
      end
    end
  end

endmodule

// File: rtl/rename_regfile_chk.sv
module rename_regfile_chk #(
  parameter int NREG = 16,
  parameter int DW   = 64,
  parameter int TW   = 4,
  localparam int AW  = $clog2(NREG)
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    iss_valid,
  input logic [AW-1:0]           iss_src_a,
  input logic [AW-1:0]           iss_dst,
  input logic [TW-1:0]           iss_tag,
  input logic                    bc_valid,
  input logic [TW-1:0]           bc_tag,
  input logic [DW-1:0]           bc_data,
  input logic [DW-1:0]           rd_a_val,
  input logic [TW-1:0]           rd_a_tag,
  input logic [NREG-1:0][DW-1:0] vals,
  input logic [NREG-1:0][TW-1:0] stat
);

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rd_a_tag == '0 && rd_a_val == '0));

  assert_dst_tag_R3: assert property (@(posedge clk) disable iff (rst)
    iss_valid |=> stat[$past(iss_dst)] == $past(iss_tag));

  assert_hit_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (bc_valid && bc_tag != '0 && stat[iss_src_a] == bc_tag &&
     !(iss_valid && iss_dst == iss_src_a))
    |=> stat[$past(iss_src_a)] == '0 && vals[$past(iss_src_a)] == $past(bc_data));

  assert_miss_keeps_R6: assert property (@(posedge clk) disable iff (rst)
    (bc_valid && stat[iss_src_a] != bc_tag)
    |=> vals[$past(iss_src_a)] == $past(vals[iss_src_a]));

  assert_forward_R7: assert property (@(posedge clk) disable iff (rst)
    (bc_valid && bc_tag != '0 && stat[iss_src_a] == bc_tag)
    |-> (rd_a_tag == '0 && rd_a_val == bc_data));

  assert_idle_bus_R9: assert property (@(posedge clk) disable iff (rst)
    (!bc_valid || bc_tag == '0) |=> $stable(vals));

endmodule

bind rename_regfile rename_regfile_chk #(.NREG(NREG), .DW(DW), .TW(TW)) chk_i (
  .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_src_a(iss_src_a),
  .iss_dst(iss_dst), .iss_tag(iss_tag), .bc_valid(bc_valid), .bc_tag(bc_tag),
  .bc_data(bc_data), .rd_a_val(rd_a_val), .rd_a_tag(rd_a_tag),
  .vals(vals), .stat(stat)
);

// File: tb/rename_regfile_tb_top.sv
module rename_regfile_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        iss_valid = 1'b0;
  logic [3:0]  iss_src_a = '0, iss_src_b = '0, iss_dst = '0, iss_tag = '0;
  logic        bc_valid = 1'b0;
  logic [3:0]  bc_tag = '0;
  logic [63:0] bc_data = '0;
  logic [63:0] rd_a_val, rd_b_val;
  logic [3:0]  rd_a_tag, rd_b_tag;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  rename_regfile dut_i (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_src_a(iss_src_a),
    .iss_src_b(iss_src_b), .iss_dst(iss_dst), .iss_tag(iss_tag),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
    .rd_a_val(rd_a_val), .rd_a_tag(rd_a_tag),
    .rd_b_val(rd_b_val), .rd_b_tag(rd_b_tag)
  );

  typedef struct packed {
    logic [3:0]  rq;
    logic        iv;
    logic [3:0]  sa, sb, dst, tag;
    logic        bv;
    logic [3:0]  bt;
    logic [63:0] bd;
    logic [63:0] eav;
    logic [3:0]  eat;
    logic [63:0] ebv;
    logic [3:0]  ebt;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{4'd3, 1'b1, 4'd1, 4'd2, 4'd1, 4'd3,  1'b0, 4'd0, 64'h0,    64'h0,  4'd0,  64'h0,  4'd0},  // R3 issue r1<-t3
    '{4'd3, 1'b1, 4'd1, 4'd2, 4'd2, 4'd5,  1'b0, 4'd0, 64'h0,    64'h0,  4'd3,  64'h0,  4'd0},  // R3 r1 pending t3
    '{4'd7, 1'b0, 4'd1, 4'd2, 4'd0, 4'd0,  1'b1, 4'd3, 64'h11,   64'h11, 4'd0,  64'h0,  4'd5},  // R7 forward
    '{4'd5, 1'b0, 4'd1, 4'd2, 4'd0, 4'd0,  1'b1, 4'd5, 64'h22,   64'h11, 4'd0,  64'h22, 4'd0},  // R5 r1 written
    '{4'd2, 1'b1, 4'd4, 4'd1, 4'd4, 4'd7,  1'b0, 4'd0, 64'h0,    64'h0,  4'd0,  64'h11, 4'd0},  // R2 ready reads
    '{4'd4, 1'b1, 4'd4, 4'd3, 4'd4, 4'd9,  1'b0, 4'd0, 64'h0,    64'h0,  4'd7,  64'h0,  4'd0},  // R4 reissue r4
    '{4'd6, 1'b0, 4'd4, 4'd4, 4'd0, 4'd0,  1'b1, 4'd7, 64'h77,   64'h0,  4'd9,  64'h0,  4'd9},  // R6 stale t7
    '{4'd6, 1'b0, 4'd4, 4'd2, 4'd0, 4'd0,  1'b0, 4'd0, 64'h0,    64'h0,  4'd9,  64'h22, 4'd0},  // R6 dropped
    '{4'd8, 1'b1, 4'd4, 4'd5, 4'd4, 4'd11, 1'b1, 4'd9, 64'h99,   64'h99, 4'd0,  64'h0,  4'd0},  // R8 collide
    '{4'd8, 1'b0, 4'd4, 4'd4, 4'd0, 4'd0,  1'b0, 4'd0, 64'h0,    64'h99, 4'd11, 64'h99, 4'd11}, // R8 result
    '{4'd9, 1'b0, 4'd6, 4'd0, 4'd0, 4'd0,  1'b1, 4'd0, 64'hdead, 64'h0,  4'd0,  64'h0,  4'd0},  // R9 tag 0
    '{4'd9, 1'b0, 4'd6, 4'd0, 4'd0, 4'd0,  1'b0, 4'd0, 64'h0,    64'h0,  4'd0,  64'h0,  4'd0},  // R9 untouched
    '{4'd3, 1'b1, 4'd7, 4'd7, 4'd7, 4'd2,  1'b0, 4'd0, 64'h0,    64'h0,  4'd0,  64'h0,  4'd0},  // R3 src==dst
    '{4'd9, 1'b0, 4'd7, 4'd1, 4'd0, 4'd0,  1'b0, 4'd2, 64'h55,   64'h0,  4'd2,  64'h11, 4'd0},  // R9 invalid bus
    '{4'd9, 1'b0, 4'd7, 4'd7, 4'd0, 4'd0,  1'b0, 4'd0, 64'h0,    64'h0,  4'd2,  64'h0,  4'd2}   // R9 untouched
  };

  task automatic check(input int rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic check_ports(input int rq, input logic [63:0] av, input logic [3:0] at,
                             input logic [63:0] bv, input logic [3:0] bt);
    check(rq, "a value", rd_a_val, av);
    check(rq, "a tag", 64'(rd_a_tag), 64'(at));
    check(rq, "b value", rd_b_val, bv);
    check(rq, "b tag", 64'(rd_b_tag), 64'(bt));
  endtask

  task automatic idle();
    iss_valid = 1'b0; bc_valid = 1'b0; bc_tag = '0; bc_data = '0;
    iss_dst = '0; iss_tag = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    iss_src_a = 4'd1; iss_src_b = 4'd2;
    @(negedge clk);
    check_ports(1, 64'h0, 4'd0, 64'h0, 4'd0);  // R1 reset state

    for (int i = 0; i < NV; i++) begin
      @(posedge clk);
      #1;
      iss_valid = VEC[i].iv;  iss_src_a = VEC[i].sa; iss_src_b = VEC[i].sb;
      iss_dst   = VEC[i].dst; iss_tag   = VEC[i].tag;
      bc_valid  = VEC[i].bv;  bc_tag    = VEC[i].bt;  bc_data = VEC[i].bd;
      @(negedge clk);
      check_ports(int'(VEC[i].rq), VEC[i].eav, VEC[i].eat, VEC[i].ebv, VEC[i].ebt);
    end

    // R1: reset in the middle of a run, with an issue and a broadcast also pending
    @(posedge clk);
    #1;
    rst = 1'b1; iss_valid = 1'b1; iss_dst = 4'd3; iss_tag = 4'd6;
    bc_valid = 1'b1; bc_tag = 4'd2; bc_data = 64'h1234;
    @(posedge clk);
    #1;
    rst = 1'b0; idle();
    iss_src_a = 4'd4; iss_src_b = 4'd7;
    @(negedge clk);
    check_ports(1, 64'h0, 4'd0, 64'h0, 4'd0);
    iss_src_a = 4'd1; iss_src_b = 4'd3;
    #1;
    check_ports(1, 64'h0, 4'd0, 64'h0, 4'd0);

    finish_run();
  end

endmodule